// File: doc/BRIEF.md
# Cascaded Rotating-Priority Interrupt Resolver

This block resolves sixteen interrupt lines held in two chained eight-input slices. Lines 0 to 7 live in the primary slice. Lines 8 to 15 live in the secondary slice. Each slice keeps a request register and an in-service register. The configuration logic supplies a mask and a lowest-priority pointer for each slice as plain inputs. Strobes set and clear request bits. Activity in the secondary slice is mirrored into input 2 of the primary slice, which acts only as the cascade link.

When the consumer pulses the acknowledge input, the block searches both slices. It looks in rotating order, starting one position after each slice's lowest-priority pointer. It moves the winning line from the request register to the in-service register and reports the line number one cycle later with a valid pulse. A pending flag tells the consumer that an unmasked request is waiting, so it knows when an acknowledge is worth issuing. Clearing of in-service bits is left to the end-of-interrupt logic outside this block.

Top module: `irq_cascade_resolver`

## Requirements
- R1: Line n for n in 0..7 maps to primary request bit n. Line n for n in 8..15 maps to secondary request bit n-8. Latching any secondary line also sets primary request bit 2.
- R2: An assert strobe on a line whose mask bit is 1 (primary mask for lines 0..7, secondary mask for lines 8..15) is ignored. The request register is left unchanged, so the line can never be granted.
- R3: `pending_o` is 1 exactly when either set is nonzero: the primary requests that are unmasked, with bit 2 excluded, or the secondary requests that are unmasked.
- R4: On acknowledge, each slice is searched from position (pointer+1) mod 8 upward. The search wraps modulo 8 and visits all eight positions once. The first unmasked request found wins.
- R5: The primary slice is searched first and its bit 2 is never granted. The secondary slice is searched only when the primary slice has no eligible request.
- R6: Granting primary line i clears primary request bit i and sets primary in-service bit i. In-service bits are never cleared by this block except by reset.
- R7: Granting secondary bit j clears secondary request bit j and sets secondary in-service bit j. It also clears primary request bit 2 and sets primary in-service bit 2.
- R8: The cycle after an acknowledge, `grant_valid_o` is 1 for one cycle. In that cycle `grant_o` is i for a primary grant, j+8 for a secondary grant, or 0xFFFF when nothing was eligible. When `grant_valid_o` is 0, `grant_o` is 0xFFFF.
- R9: A deassert strobe clears that line's request bit. For a secondary line, primary request bit 2 is also cleared if the secondary request register becomes zero.
- R10: When assert and deassert strobes for the same line come in the same cycle, the deassert wins and the request bit ends cleared.
- R11: After reset, all request and in-service bits are 0, `pending_o` is 0, `grant_valid_o` is 0 and `grant_o` is 0xFFFF.
- R12: An acknowledge evaluates the request registers as they stood before that cycle. Strobes that arrive in the same cycle are applied after the grant's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| assert_i | input | 16 | Per-line request set strobes |
| deassert_i | input | 16 | Per-line request clear strobes |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| pri_mask_i | input | 8 | Primary slice mask, 1 = masked |
| sec_mask_i | input | 8 | Secondary slice mask, 1 = masked |
| pri_low_i | input | 3 | Primary lowest-priority pointer |
| sec_low_i | input | 3 | Secondary lowest-priority pointer |
| pending_o | output | 1 | Unmasked request waiting |
| grant_o | output | 16 | Granted line number or 0xFFFF |
| grant_valid_o | output | 1 | Grant result valid, one cycle |
| pri_isr_o | output | 8 | Primary in-service register |
| sec_isr_o | output | 8 | Secondary in-service register |

## Verification
The bench builds the block with its default parameters: eight lines per slice, the cascade link at primary input 2, and a sixteen-bit grant code. These values make all sixteen lines reachable. They also allow tests where pointer wrap-around lands on the cascade position, where the primary search skips bit 2 while that bit is set, and where a secondary grant leaves other secondary requests in place. Expected grants are queued by the driver from a requirement-level model and compared when the valid pulse appears.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned DEF_SLICE_W = 8;
  localparam int unsigned DEF_CASC_IDX = 2;
  localparam int unsigned DEF_GNT_W = 16;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_SEC  = 2'd2
  } gnt_src_e;
endpackage

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  input  logic [IW-1:0] low_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  // first set bit at or after low+1, wrapping once
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < int'(W); k++) begin
      int p;
      p = (int'(low_i) + 1 + k) % int'(W);
      if (!hit_o && req_i[p]) begin
        hit_o = 1'b1;
        idx_o = IW'(p);
      end
    end
    onehot_o = hit_o ? (W'(1) << idx_o) : '0;
  end

  always_comb begin
    if (hit_o) a_pick_in_req_r4: assert (req_i[idx_o]);
    if (req_i != '0) a_pick_found_r4: assert (hit_o);
  end
endmodule

// File: rtl/irq_slice.sv
module irq_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] take_i,
  output logic [W-1:0] irr_o,
  output logic [W-1:0] irr_nxt_o,
  output logic [W-1:0] isr_o
);
  logic [W-1:0] irr_q, isr_q;

  // grant clear first, then strobes; clear beats set
  assign irr_nxt_o = ((irr_q & ~take_i) | set_i) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_nxt_o;
      isr_q <= isr_q | take_i;
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;

  p_take_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i != '0) |=> ((isr_q & $past(take_i)) == $past(take_i)));
  p_isr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((isr_q & $past(isr_q)) == $past(isr_q)));
  p_clr_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((irr_q & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned SLICE_W  = DEF_SLICE_W,
  parameter int unsigned CASC_IDX = DEF_CASC_IDX,
  parameter int unsigned GNT_W    = DEF_GNT_W,
  localparam int unsigned LINES   = 2 * SLICE_W,
  localparam int unsigned IW      = $clog2(SLICE_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LINES-1:0]   assert_i,
  input  logic [LINES-1:0]   deassert_i,
  input  logic               ack_i,
  input  logic [SLICE_W-1:0] pri_mask_i,
  input  logic [SLICE_W-1:0] sec_mask_i,
  input  logic [IW-1:0]      pri_low_i,
  input  logic [IW-1:0]      sec_low_i,
  output logic               pending_o,
  output logic [GNT_W-1:0]   grant_o,
  output logic               grant_valid_o,
  output logic [SLICE_W-1:0] pri_isr_o,
  output logic [SLICE_W-1:0] sec_isr_o
);
  localparam logic [SLICE_W-1:0] CASC_BIT = SLICE_W'(1) << CASC_IDX;
  localparam logic [GNT_W-1:0]   NONE     = '1;

  logic [SLICE_W-1:0] pri_irr, pri_nxt, sec_irr, sec_nxt;
  logic [SLICE_W-1:0] pri_set, pri_clr, sec_set, sec_clr;
  logic [SLICE_W-1:0] pri_cand, sec_cand, pri_oh, sec_oh;
  logic [SLICE_W-1:0] pri_take, sec_take;
  logic [IW-1:0]      pri_idx, sec_idx;
  logic               pri_hit, sec_hit;
  gnt_src_e           src;
  logic [GNT_W-1:0]   grant_q;
  logic               valid_q;

  // strobe steering
  assign sec_set = assert_i[LINES-1:SLICE_W] & ~sec_mask_i;
  assign sec_clr = deassert_i[LINES-1:SLICE_W];
  assign pri_set = (assert_i[SLICE_W-1:0] & ~pri_mask_i)
                 | ((sec_set != '0) ? CASC_BIT : '0);
  assign pri_clr = deassert_i[SLICE_W-1:0]
                 | (((sec_clr != '0) && (sec_nxt == '0)) ? CASC_BIT : '0);

  // eligibility
  assign pri_cand  = pri_irr & ~pri_mask_i & ~CASC_BIT;
  assign sec_cand  = sec_irr & ~sec_mask_i;
  assign pending_o = (pri_cand != '0) || (sec_cand != '0);

  irq_rot_pick #(.W(SLICE_W)) u_pick_pri (
    .req_i(pri_cand), .low_i(pri_low_i),
    .hit_o(pri_hit), .idx_o(pri_idx), .onehot_o(pri_oh)
  );

  irq_rot_pick #(.W(SLICE_W)) u_pick_sec (
    .req_i(sec_cand), .low_i(sec_low_i),
    .hit_o(sec_hit), .idx_o(sec_idx), .onehot_o(sec_oh)
  );

  always_comb begin
    src = SRC_NONE;
    if (ack_i) begin
      if (pri_hit)      src = SRC_PRI;
      else if (sec_hit) src = SRC_SEC;
    end
  end

  assign sec_take = (src == SRC_SEC) ? sec_oh : '0;
  assign pri_take = (src == SRC_PRI) ? pri_oh
                  : (src == SRC_SEC) ? CASC_BIT : '0;

  irq_slice #(.W(SLICE_W)) u_slice_pri (
    .clk_i, .rst_ni, .set_i(pri_set), .clr_i(pri_clr), .take_i(pri_take),
    .irr_o(pri_irr), .irr_nxt_o(pri_nxt), .isr_o(pri_isr_o)
  );

  irq_slice #(.W(SLICE_W)) u_slice_sec (
    .clk_i, .rst_ni, .set_i(sec_set), .clr_i(sec_clr), .take_i(sec_take),
    .irr_o(sec_irr), .irr_nxt_o(sec_nxt), .isr_o(sec_isr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ack_i;
      unique case (src)
        SRC_PRI: grant_q <= GNT_W'(pri_idx);
        SRC_SEC: grant_q <= GNT_W'(sec_idx) + GNT_W'(SLICE_W);
        default: grant_q <= NONE;
      endcase
    end
  end

  assign grant_o       = grant_q;
  assign grant_valid_o = valid_q;

  p_valid_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> grant_valid_o);
  p_no_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (!grant_valid_o && grant_o == NONE));
  p_none_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pending_o) |=> (grant_o == NONE));
  p_no_cascade_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_o != GNT_W'(CASC_IDX)));
  p_cascade_isr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && grant_o != NONE && grant_o >= GNT_W'(SLICE_W))
      |-> pri_isr_o[CASC_IDX]);
  p_cascade_mirror_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_set != '0 && sec_nxt != '0) |=> pri_irr[CASC_IDX]);
endmodule

// File: tb/irq_cascade_resolver_bench.sv
module irq_cascade_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_s = '0, d_s = '0;
  logic        ack = 1'b0;
  logic [7:0]  pmask = '0, smask = '0;
  logic [2:0]  plow = 3'd7, slow = 3'd7;
  logic        pending, gvalid;
  logic [15:0] grant;
  logic [7:0]  pisr, sisr;

  int checks = 0, errors = 0;
  logic [15:0] expq[$];
  logic [7:0] m_pirr = '0, m_sirr = '0, m_pisr = '0, m_sisr = '0;

  always #4 clk = ~clk;

  irq_cascade_resolver u_irq_cascade_resolver (
    .clk_i(clk), .rst_ni(rst_n), .assert_i(a_s), .deassert_i(d_s), .ack_i(ack),
    .pri_mask_i(pmask), .sec_mask_i(smask), .pri_low_i(plow), .sec_low_i(slow),
    .pending_o(pending), .grant_o(grant), .grant_valid_o(gvalid),
    .pri_isr_o(pisr), .sec_isr_o(sisr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [7:0] c, input logic [2:0] low);
    for (int k = 1; k <= 8; k++) begin
      int p;
      p = (int'(low) + k) % 8;
      if (c[p]) return p;
    end
    return -1;
  endfunction

  // driver: one cycle of stimulus, model update, expected grant queued
  task automatic step(input logic [15:0] a, input logic [15:0] d, input logic k);
    logic [7:0] ps, ss;
    int ip, is;
    a_s = a; d_s = d; ack = k;
    if (k) begin
      ip = pick(m_pirr & ~pmask & 8'hFB, plow);
      is = pick(m_sirr & ~smask, slow);
      if (ip >= 0) begin
        expq.push_back(16'(ip));
        m_pirr[ip] = 1'b0; m_pisr[ip] = 1'b1;
      end else if (is >= 0) begin
        expq.push_back(16'(is + 8));
        m_sirr[is] = 1'b0; m_sisr[is] = 1'b1;
        m_pirr[2] = 1'b0; m_pisr[2] = 1'b1;
      end else expq.push_back(16'hFFFF);
    end
    ss = a[15:8] & ~smask;
    ps = a[7:0] & ~pmask;
    m_sirr = (m_sirr | ss) & ~d[15:8];
    m_pirr = (m_pirr | ps | ((ss != 0) ? 8'h04 : 8'h00)) & ~d[7:0];
    if (d[15:8] != 0 && m_sirr == 0) m_pirr[2] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    a_s = '0; d_s = '0; ack = 1'b0;
  endtask

  task automatic chk_state(input string req);
    chk({req, " pending"}, 16'(pending),
        16'(((m_pirr & ~pmask & 8'hFB) != 0) || ((m_sirr & ~smask) != 0)));
    chk({req, " pri isr"}, 16'(pisr), 16'(m_pisr));
    chk({req, " sec isr"}, 16'(sisr), 16'(m_sisr));
  endtask

  // monitor: compare each valid grant against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (gvalid) begin
        if (expq.size() == 0) chk("R8 unexpected valid", 16'h1, 16'h0);
        else chk("R4/R5/R8 grant", grant, expq.pop_front());
      end else chk("R8 idle grant", grant, 16'hFFFF);
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset valid", 16'(gvalid), 16'h0);
    chk_state("R11");
    step('0, '0, 1'b1);                          // R8 nothing eligible
    chk_state("R8");
    step(16'h0020, '0, 1'b0);                    // R1 line 5
    chk_state("R3");
    step('0, '0, 1'b1); chk_state("R6");         // grant 5
    pmask = 8'h08;
    step(16'h0008, '0, 1'b0); chk_state("R2 masked");
    pmask = 8'h00;
    step('0, '0, 1'b1); chk_state("R2 no grant");
    plow = 3'd4;                                 // R4 rotation: 6,1,4
    step(16'h0052, '0, 1'b0);
    step('0, '0, 1'b1); step('0, '0, 1'b1); step('0, '0, 1'b1);
    chk_state("R4");
    step(16'h0401, '0, 1'b0); chk_state("R1 cascade");
    step('0, '0, 1'b1); chk_state("R5 primary first");
    step('0, '0, 1'b1); chk_state("R7 secondary grant");
    step(16'h1000, '0, 1'b0);
    step('0, 16'h1000, 1'b0); chk_state("R9 deassert");
    step('0, '0, 1'b1);
    step(16'h0A00, '0, 1'b0);
    step('0, 16'h0200, 1'b0); chk_state("R9 partial");
    step('0, '0, 1'b1); chk_state("R9 grant 11");
    step(16'h0080, 16'h0080, 1'b0); chk_state("R10 same cycle");
    step('0, '0, 1'b1);
    slow = 3'd1; smask = 8'h20;                  // R4 secondary pointer, R2 secondary mask
    step(16'h2900, '0, 1'b0); chk_state("R2 sec mask");
    step('0, '0, 1'b1); step('0, '0, 1'b1); step('0, '0, 1'b1);
    chk_state("R4 sec wrap");
    smask = 8'h00;
    step(16'h0004, '0, 1'b0); chk_state("R5 bit2 only");
    step('0, '0, 1'b1); chk_state("R5 bit2 skipped");
    step('0, 16'h0004, 1'b0);
    plow = 3'd7;
    step(16'h0003, '0, 1'b0);
    step(16'h0004, '0, 1'b1);                    // R12 ack with same-cycle strobe
    chk_state("R12");
    step('0, '0, 1'b1); chk_state("R12 follow");
    step('0, '0, 1'b0);
    chk("R8 queue drained", 16'(expq.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule